// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block is a small memory-mapped timer. A single 16-bit up-counter and its period register are shared by a parameterised set of compare channels, up to six. Each channel turns the shared count into an edge-aligned PWM waveform whose active level can be chosen per channel. A power-of-two prescaler divides the input clock before it reaches the counter. The counter runs from zero up to the period value and then wraps to zero. Each channel's compare value sets how many prescaled ticks of every period the pulse lasts.

Software reaches the block through a plain register bus: an address, a write strobe, write data, and read data that is decoded combinationally. The register layout keeps the offsets and bit positions that driver software decodes. Writes to the period and compare registers are buffered while the counter runs, and they take effect together at the next wrap. While the counter is stopped, the same writes take effect at once. Each channel has a sticky match flag that software clears by writing 1 to it.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, the control register reads 0, the counter reads 0, the period register reads 0xFFFF, every channel register reads 0 and every PWM output is low.
- R2: Offset 0x04 reads the channel count in bits [7:0] and ignores writes; any unmapped offset, including 0x08, reads 0.
- R3: The control register at 0x10 holds the prescaler exponent in bits [2:0], the clock mode in bits [4:3] and the centre-aligned select in bit 5. The counter advances only in clock mode 01; in modes 00, 10 and 11 it holds its value.
- R4: While running, the counter advances by one every 2^PS input clocks, from 0 up to the active period value, then wraps to 0. Any write to the counter register at 0x14 clears it to 0.
- R5: The period register at 0x18 is 16 bits wide. While the clock mode is not 01, a write to it becomes the active period on the following cycle.
- R6: While the counter runs, period and compare writes read back at once but become active only at the next wrap of the counter.
- R7: Channel n has a control register at 0x20+8n and a 16-bit compare register at 0x24+8n. In the control register, bit 7 is the match flag, bits [5:4] the mode, bits [3:2] the level select, and the other bits read 0.
- R8: With mode 10, level 10 and centre select 0, the output goes low on the tick where the count becomes the compare value. It goes high on the tick where the count wraps to 0, except when the compare value is 0, in which case the match wins. A compare value above the period keeps the output high.
- R9: Level 01 gives the inverted waveform. Any mode other than 10, level 00 or 11, or centre select 1 holds the output low. A level change shows on the output in the cycle after the write.
- R10: While the counter is not running, a high-true channel drives high and a low-true channel drives low.
- R11: A channel's flag sets on every tick where the count becomes its compare value. Writing 1 to bit 7 clears the flag, writing 0 leaves it unchanged, and a set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | CNT_W (16) | Write data |
| bus_rdata | output | CNT_W (16) | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (4) | Per-channel PWM outputs |

## Verification
The assertions assume that the bus presents at most one write per cycle. They also assume that the counter register is written only while the counter is stopped, since a clear mid-run is not treated as a wrap. The bench's stimulus touches the counter register only after stopping the clock mode. It moves the period and compare values only between settled windows, so each duty measurement covers one whole steady period. A behavioural model runs beside the design and is compared with the outputs and the read data on every cycle. Directed checks also count high cycles per period against duty values worked out by hand.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  // Register offsets; software decodes these, so they stay fixed.
  localparam logic [7:0] OFS_PARAM     = 8'h04;
  localparam logic [7:0] OFS_CTRL      = 8'h10;
  localparam logic [7:0] OFS_COUNT     = 8'h14;
  localparam logic [7:0] OFS_PERIOD    = 8'h18;
  localparam logic [7:0] OFS_CH_BASE   = 8'h20;
  localparam int         CH_STRIDE     = 8;
  localparam int         CH_VAL_OFS    = 4;

  typedef enum logic [1:0] {
    CK_OFF  = 2'b00,
    CK_RUN  = 2'b01,
    CK_RSV2 = 2'b10,
    CK_RSV3 = 2'b11
  } clk_mode_e;

  localparam logic [1:0] MODE_EDGE = 2'b10;
  localparam logic [1:0] LVL_HIGH  = 2'b10;
  localparam logic [1:0] LVL_LOW   = 2'b01;

  function automatic logic [7:0] ch_ctl_addr(input int unsigned idx);
    return OFS_CH_BASE + 8'(idx * CH_STRIDE);
  endfunction

  function automatic logic [7:0] ch_val_addr(input int unsigned idx);
    return OFS_CH_BASE + 8'(idx * CH_STRIDE + CH_VAL_OFS);
  endfunction

endpackage

// File: rtl/pwmt_rst_sync.sv
module pwmt_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/pwmt_timebase.sv
module pwmt_timebase #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             cnt_clr_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] period_o,
  output logic             tick_o,
  output logic             reload_o,
  output logic [CNT_W-1:0] next_cnt_o
);

  localparam int PC_W = (1 << PS_W) - 1;

  logic [PC_W-1:0]  pre_q, pre_d, pre_lim;
  logic             pre_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] per_buf_q, per_buf_d, per_act_q, per_act_d;
  logic             per_buf_en, per_act_en;

  always_comb begin
    pre_lim    = PC_W'((1 << ps_i) - 1);
    tick_o     = run_i && (pre_q >= pre_lim);
    reload_o   = tick_o && (cnt_q == per_act_q);
    next_cnt_o = reload_o ? '0 : cnt_q + 1'b1;
  end

  // next state
  always_comb begin
    pre_en = run_i || (pre_q != '0) || cnt_clr_i;
    if (!run_i || tick_o || cnt_clr_i) pre_d = '0;
    else                               pre_d = pre_q + 1'b1;

    cnt_en = cnt_clr_i || tick_o;
    cnt_d  = cnt_clr_i ? '0 : next_cnt_o;

    per_buf_en = per_we_i;
    per_buf_d  = per_wdata_i;

    per_act_en = !run_i || reload_o;
    if (!run_i) per_act_d = per_we_i ? per_wdata_i : per_buf_q;
    else        per_act_d = per_buf_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      cnt_q     <= '0;
      per_buf_q <= '1;
      per_act_q <= '1;
    end else begin
      if (pre_en)     pre_q     <= pre_d;
      if (cnt_en)     cnt_q     <= cnt_d;
      if (per_buf_en) per_buf_q <= per_buf_d;
      if (per_act_en) per_act_q <= per_act_d;
    end
  end

  assign count_o  = cnt_q;
  assign period_o = per_buf_q;

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    reload_o |=> (count_o == '0));

  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick_o && !reload_o && !cnt_clr_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_i && !cnt_clr_i) |=> $stable(count_o));

  a_r5_period_direct: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_i && per_we_i) |=> (per_act_q == $past(per_wdata_i)));

  a_r6_period_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_i && !reload_o) |=> $stable(per_act_q));

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] next_cnt_i,
  input  logic             edge_ok_i,
  input  logic             ctl_we_i,
  input  logic             val_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [7:0]       ctl_o,
  output logic [CNT_W-1:0] val_o,
  output logic             pwm_o
);

  logic [1:0]       mode_q, lvl_q;
  logic             flag_q, flag_d, flag_en;
  logic [CNT_W-1:0] val_buf_q, val_act_q, val_act_d;
  logic             val_act_en;
  logic             phase_q, phase_d, phase_en;
  logic             hit, active;

  assign hit = tick_i && (next_cnt_i == val_act_q);

  // next state
  always_comb begin
    flag_en = hit || (ctl_we_i && wdata_i[7]);
    flag_d  = hit;

    val_act_en = !run_i || reload_i;
    if (!run_i) val_act_d = val_we_i ? wdata_i : val_buf_q;
    else        val_act_d = val_buf_q;

    phase_en = !run_i || hit || (tick_i && next_cnt_i == '0);
    if (!run_i)   phase_d = 1'b1;
    else if (hit) phase_d = 1'b0;
    else          phase_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      lvl_q     <= '0;
      flag_q    <= 1'b0;
      val_buf_q <= '0;
      val_act_q <= '0;
      phase_q   <= 1'b1;
    end else begin
      if (ctl_we_i) begin
        mode_q <= wdata_i[5:4];
        lvl_q  <= wdata_i[3:2];
      end
      if (flag_en)    flag_q    <= flag_d;
      if (val_we_i)   val_buf_q <= wdata_i;
      if (val_act_en) val_act_q <= val_act_d;
      if (phase_en)   phase_q   <= phase_d;
    end
  end

  assign active = edge_ok_i && (mode_q == MODE_EDGE) &&
                  ((lvl_q == LVL_HIGH) || (lvl_q == LVL_LOW));
  assign pwm_o  = active && ((lvl_q == LVL_HIGH) ? phase_q : !phase_q);
  assign ctl_o  = {flag_q, 1'b0, mode_q, lvl_q, 2'b00};
  assign val_o  = val_buf_q;

  a_r11_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |=> flag_q);

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !(ctl_we_i && wdata_i[7])) |=> flag_q);

  a_r10_pause_asserted: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_i |=> phase_q);

  a_r8_hit_deasserts: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_i && hit) |=> !phase_q);

  a_r6_compare_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_i && !reload_i) |=> $stable(val_act_q));

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwmt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  logic             rst_i;
  logic [PS_W-1:0]  ps_q;
  clk_mode_e        ck_q;
  logic             ctr_q;
  logic             ctrl_we, cnt_clr, per_we, run;
  logic [CNT_W-1:0] count, period, next_cnt;
  logic             tick, reload;

  logic [NUM_CH-1:0] ctl_we, val_we;
  logic [7:0]        ctl_rd [NUM_CH];
  logic [CNT_W-1:0]  val_rd [NUM_CH];

  pwmt_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_i)
  );

  assign ctrl_we = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign cnt_clr = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
  assign per_we  = bus_we && (bus_addr == ADDR_W'(OFS_PERIOD));
  assign run     = (ck_q == CK_RUN);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ps_q  <= '0;
      ck_q  <= CK_OFF;
      ctr_q <= 1'b0;
    end else if (ctrl_we) begin
      ps_q  <= bus_wdata[PS_W-1:0];
      ck_q  <= clk_mode_e'(bus_wdata[4:3]);
      ctr_q <= bus_wdata[5];
    end
  end

  pwmt_timebase #(.CNT_W(CNT_W), .PS_W(PS_W)) u_tb (
    .clk         (clk),
    .rst_ni      (rst_i),
    .run_i       (run),
    .ps_i        (ps_q),
    .cnt_clr_i   (cnt_clr),
    .per_we_i    (per_we),
    .per_wdata_i (bus_wdata),
    .count_o     (count),
    .period_o    (period),
    .tick_o      (tick),
    .reload_o    (reload),
    .next_cnt_o  (next_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctl_we[c] = bus_we && (bus_addr == ADDR_W'(ch_ctl_addr(c)));
    assign val_we[c] = bus_we && (bus_addr == ADDR_W'(ch_val_addr(c)));

    pwmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_ni     (rst_i),
      .run_i      (run),
      .tick_i     (tick),
      .reload_i   (reload),
      .next_cnt_i (next_cnt),
      .edge_ok_i  (!ctr_q),
      .ctl_we_i   (ctl_we[c]),
      .val_we_i   (val_we[c]),
      .wdata_i    (bus_wdata),
      .ctl_o      (ctl_rd[c]),
      .val_o      (val_rd[c]),
      .pwm_o      (pwm_out[c])
    );
  end

  // read decode
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_PARAM))  bus_rdata = CNT_W'(NUM_CH);
    if (bus_addr == ADDR_W'(OFS_CTRL))   bus_rdata = CNT_W'({ctr_q, ck_q, ps_q});
    if (bus_addr == ADDR_W'(OFS_COUNT))  bus_rdata = count;
    if (bus_addr == ADDR_W'(OFS_PERIOD)) bus_rdata = period;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(ch_ctl_addr(c))) bus_rdata = CNT_W'(ctl_rd[c]);
      if (bus_addr == ADDR_W'(ch_val_addr(c))) bus_rdata = val_rd[c];
    end
  end

  a_r9_centre_mute: assert property (@(posedge clk) disable iff (!rst_i)
    ctr_q |-> (pwm_out == '0));

  a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_i)
    $countones({ctrl_we, cnt_clr, per_we, ctl_we, val_we}) <= 1);

endmodule

// File: tb/tb_pwm_timer_bank.sv
module tb_pwm_timer_bank;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] addr;
  logic we;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [NCH-1:0] pwm;

  always #4 clk = ~clk;

  pwm_timer_bank #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_ps, m_ck, m_ctr, m_pre, m_cnt, m_pbuf, m_pact;
  int m_ms[NCH], m_lvl[NCH], m_flag[NCH], m_vbuf[NCH], m_vact[NCH], m_ph[NCH];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_out(int c);
    bit act = (m_ctr == 0) && (m_ms[c] == 2) && (m_lvl[c] == 2 || m_lvl[c] == 1);
    if (!act) return 0;
    return (m_lvl[c] == 2) ? m_ph[c] : 1 - m_ph[c];
  endfunction

  function automatic int m_read(int a);
    if (a == 8'h04) return NCH;
    if (a == 8'h10) return (m_ctr << 5) | (m_ck << 3) | m_ps;
    if (a == 8'h14) return m_cnt;
    if (a == 8'h18) return m_pbuf;
    for (int c = 0; c < NCH; c++) begin
      if (a == 8'h20 + 8 * c) return (m_flag[c] << 7) | (m_ms[c] << 4) | (m_lvl[c] << 2);
      if (a == 8'h24 + 8 * c) return m_vbuf[c];
    end
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int run, lim, tick, rel, nxt, wper, wcnt, wctl, wval;
    int hit[NCH];
    if (!rst_n) begin
      m_ps = 0; m_ck = 0; m_ctr = 0; m_pre = 0; m_cnt = 0;
      m_pbuf = 16'hFFFF; m_pact = 16'hFFFF;
      for (int c = 0; c < NCH; c++) begin
        m_ms[c] = 0; m_lvl[c] = 0; m_flag[c] = 0;
        m_vbuf[c] = 0; m_vact[c] = 0; m_ph[c] = 1;
      end
    end else begin
      run  = (m_ck == 1);
      lim  = (1 << m_ps) - 1;
      tick = run && (m_pre >= lim);
      rel  = tick && (m_cnt == m_pact);
      nxt  = rel ? 0 : ((m_cnt + 1) & 16'hFFFF);
      wper = we && addr == 8'h18;
      wcnt = we && addr == 8'h14;
      for (int c = 0; c < NCH; c++) hit[c] = tick && (nxt == m_vact[c]);
      if (!run || tick || wcnt) m_pre = 0; else m_pre++;
      if (wcnt) m_cnt = 0; else if (tick) m_cnt = nxt;
      if (!run) m_pact = wper ? int'(wdata) : m_pbuf;
      else if (rel) m_pact = m_pbuf;
      if (wper) m_pbuf = wdata;
      for (int c = 0; c < NCH; c++) begin
        wctl = we && addr == 8'h20 + 8 * c;
        wval = we && addr == 8'h24 + 8 * c;
        if (!run) m_vact[c] = wval ? int'(wdata) : m_vbuf[c];
        else if (rel) m_vact[c] = m_vbuf[c];
        if (wval) m_vbuf[c] = wdata;
        if (!run) m_ph[c] = 1;
        else if (hit[c]) m_ph[c] = 0;
        else if (tick && nxt == 0) m_ph[c] = 1;
        if (hit[c]) m_flag[c] = 1;
        else if (wctl && wdata[7]) m_flag[c] = 0;
        if (wctl) begin m_ms[c] = wdata[5:4]; m_lvl[c] = wdata[3:2]; end
      end
      if (we && addr == 8'h10) begin
        m_ps = wdata[2:0]; m_ck = wdata[4:3]; m_ctr = wdata[5];
      end
    end
    #2;
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) check("R8 per-cycle pwm vs model", pwm[c], m_out(c));
      check("R7 per-cycle read vs model", rdata, m_read(addr));
    end
  end

  task automatic rd(int a, int exp, string req);
    @(negedge clk); addr = a; we = 0; #1;
    check(req, rdata, exp);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(posedge clk); #1 we = 0;
  endtask

  task automatic duty(int c, int n, int exp, string req);
    int h = 0;
    repeat (n) begin @(negedge clk); h += pwm[c]; end
    check(req, h, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; we = 0; addr = 0; wdata = 0;
    idle(3); rst_n = 1; idle(4);

    // R1 reset state
    rd(8'h10, 0, "R1 ctrl reset");
    rd(8'h18, 16'hFFFF, "R1 period reset");
    rd(8'h14, 0, "R1 count reset");
    rd(8'h20, 0, "R1 ch ctl reset");
    check("R1 outputs low", pwm, 0);

    // R2 parameter and unmapped
    rd(8'h04, NCH, "R2 channel count");
    wr(8'h04, 16'h00AB);
    rd(8'h04, NCH, "R2 param ignores write");
    rd(8'h08, 0, "R2 unmapped 0x08");

    // R5 period while stopped
    wr(8'h18, 9);
    rd(8'h18, 9, "R5 period readback");

    // channel setup: ch0 high cmp4, ch1 low cmp7, ch2 high cmp0, ch3 high cmp20
    wr(8'h20, 16'h0028); wr(8'h24, 4);
    wr(8'h28, 16'h0024); wr(8'h2C, 7);
    wr(8'h30, 16'h0028); wr(8'h34, 0);
    wr(8'h38, 16'h0028); wr(8'h3C, 20);
    rd(8'h3C, 20, "R7 ch3 compare offset");
    idle(1);
    check("R10 stopped levels", pwm, 4'b1101);

    // run, PS=0, period 10
    wr(8'h10, 16'h0008);
    idle(25);
    duty(0, 10, 4, "R8 high-true cmp4");
    duty(1, 10, 3, "R9 low-true cmp7");
    duty(2, 10, 0, "R8 cmp0 zero duty");
    duty(3, 10, 10, "R8 cmp above period");

    // R4 prescaler 4
    wr(8'h10, 16'h000A);
    idle(100);
    duty(0, 40, 16, "R4 prescaled duty");

    // R6 buffered period and compare
    wr(8'h18, 4);
    rd(8'h18, 4, "R6 period readback while running");
    idle(60);
    duty(0, 20, 16, "R6 new period applied");
    duty(1, 20, 0, "R6 low-true cmp above period");
    wr(8'h24, 2);
    idle(60);
    duty(0, 20, 8, "R6 new compare applied");

    // R11 flag
    rd(8'h20, 16'h00A8, "R11 flag set by match");
    wr(8'h10, 0);
    idle(2);
    check("R10 paused levels", pwm, 4'b1101);
    wr(8'h20, 16'h0028);
    rd(8'h20, 16'h00A8, "R11 write 0 keeps flag");
    wr(8'h20, 16'h00A8);
    rd(8'h20, 16'h0028, "R11 write 1 clears flag");

    // R9 polarity change and disables
    wr(8'h20, 16'h0024);
    idle(1);
    check("R9 polarity change", pwm[0], 0);
    wr(8'h30, 16'h002C);
    idle(1);
    check("R9 level 11 mutes", pwm[2], 0);
    wr(8'h10, 16'h0028);
    idle(20);
    check("R9 centre select mutes", pwm, 0);

    // R3 hold in reserved clock mode, R4 counter clear
    wr(8'h10, 16'h0008);
    idle(7);
    wr(8'h10, 16'h0010);
    begin
      logic [15:0] snap;
      @(negedge clk); addr = 8'h14; #1 snap = rdata;
      idle(6); #1;
      check("R3 counter holds in mode 10", rdata, snap);
    end
    wr(8'h14, 16'h1234);
    rd(8'h14, 0, "R4 counter write clears");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule